// File: doc/BRIEF.md
# Debounced Power Source Detector

This block turns three raw supply-presence comparator levels (battery, DC adapter, USB VBUS) into clean detected-status bits. It does this by requiring each change to persist for a number of millisecond ticks. Every confirmed change produces a one-cycle insertion or removal event pulse. It also sets a sticky per-source interrupt flag, which software clears by writing one.

Software can switch off filtering for any source. The status then follows the comparator on the next clock. The DC and USB paths use a parameterised period, nominally 100 ticks. The battery path takes separate insertion and removal tick counts from inputs, so removal can be confirmed quickly and insertion slowly.

Each source runs a four-state machine:
- ABSENT goes to ARMING when the raw input goes high with filtering on, or straight to PRESENT with filtering off (insert).
- ARMING goes back to ABSENT if the input drops (glitch). It goes to PRESENT when the insert count completes or filtering is turned off (insert).
- PRESENT goes to DISARMING when the raw input goes low with filtering on, or straight to ABSENT with filtering off (remove).
- DISARMING goes back to PRESENT if the input returns high. It goes to ABSENT when the remove count completes or filtering is turned off (remove).

Top module: `pwr_src_detect`

## Requirements
- R1: After reset, status, flags, insertion events and removal events are all 0.
- R2: With filtering on, a low-to-high raw change sets status only after the raw input has stayed high through the configured number of tick-high cycles, counted from the cycle after the change was first seen. DC and USB use DBNC_MS ticks.
- R3: With filtering on, status clears only after the raw input has stayed low through the full removal tick count.
- R4: If the raw input returns to the current status level before the count completes, the status does not change, and the count restarts on the next mismatch.
- R5: With filtering off, status equals the raw input sampled at the previous clock edge.
- R6: The battery path (bit 0) uses bat_ins_ms ticks for insertion and bat_rem_ms ticks for removal. A value of 0 behaves as 1.
- R7: ins_evt is a one-cycle pulse in the first cycle status reads 1. rem_evt is a one-cycle pulse in the first cycle status reads 0. The two never assert together.
- R8: A flag reads 1 from the cycle after an event pulse of its source and stays set until cleared.
- R9: Writing 1 to a flag_clr bit clears that flag on the next cycle. An event pulse present in the same cycle keeps the flag set.
- R10: Bit positions are fixed as 0 = battery, 1 = DC adapter, 2 = USB VBUS, on every per-source port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| raw_in | input | 3 | Raw comparator levels |
| dbnc_en | input | 3 | Per-source filtering enable |
| bat_ins_ms | input | CNT_W | Battery insertion tick count |
| bat_rem_ms | input | CNT_W | Battery removal tick count |
| flag_clr | input | 3 | Write-one-to-clear strobes for flags |
| status | output | 3 | Detected status per source |
| flags | output | 3 | Sticky change flags |
| ins_evt | output | 3 | Insertion event pulses |
| rem_evt | output | 3 | Removal event pulses |

## Verification
If a state machine sits in the wrong state, status disagrees with the reference model either at once or on the next tick that completes a count. A wrong tick counter shifts the status edge by whole tick periods, which can show up as much as 200 cycles late. A lost or doubled event shows in the pulse outputs in the same cycle, and in the flag one cycle later. A wrong flag clear priority shows on the cycle after a clear coincides with an event.

// File: rtl/pwrdet_pkg.sv
package pwrdet_pkg;
    localparam int NSRC    = 3;
    localparam int BAT_IDX = 0;
    localparam int DC_IDX  = 1;
    localparam int USB_IDX = 2;

    typedef enum logic [1:0] {
        ST_ABSENT    = 2'd0,
        ST_ARMING    = 2'd1,
        ST_PRESENT   = 2'd2,
        ST_DISARMING = 2'd3
    } det_state_t;
endpackage

// File: rtl/pwrdet_filter.sv
module pwrdet_filter
    import pwrdet_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             raw,
    input  logic             dbnc_en,
    input  logic [CNT_W-1:0] rise_lim,
    input  logic [CNT_W-1:0] fall_lim,
    output logic             status,
    output logic             ev_ins,
    output logic             ev_rem
);
    localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

    det_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic           go_ins, go_rem;
    logic [CNT_W:0] cnt_nx, rise_eff, fall_eff;

    assign cnt_nx   = {1'b0, cnt_q} + ONE;
    assign rise_eff = (rise_lim == '0) ? ONE : {1'b0, rise_lim};
    assign fall_eff = (fall_lim == '0) ? ONE : {1'b0, fall_lim};

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        go_ins  = 1'b0;
        go_rem  = 1'b0;
        unique case (state_q)
            ST_ABSENT: begin
                if (raw) begin
                    if (!dbnc_en) begin
                        state_d = ST_PRESENT;
                        go_ins  = 1'b1;
                    end else begin
                        state_d = ST_ARMING;
                        cnt_d   = '0;
                    end
                end
            end
            ST_ARMING: begin
                if (!raw) begin
                    state_d = ST_ABSENT;
                end else if (!dbnc_en || (tick && cnt_nx >= rise_eff)) begin
                    state_d = ST_PRESENT;
                    go_ins  = 1'b1;
                end else if (tick) begin
                    cnt_d = cnt_nx[CNT_W-1:0];
                end
            end
            ST_PRESENT: begin
                if (!raw) begin
                    if (!dbnc_en) begin
                        state_d = ST_ABSENT;
                        go_rem  = 1'b1;
                    end else begin
                        state_d = ST_DISARMING;
                        cnt_d   = '0;
                    end
                end
            end
            ST_DISARMING: begin
                if (raw) begin
                    state_d = ST_PRESENT;
                end else if (!dbnc_en || (tick && cnt_nx >= fall_eff)) begin
                    state_d = ST_ABSENT;
                    go_rem  = 1'b1;
                end else if (tick) begin
                    cnt_d = cnt_nx[CNT_W-1:0];
                end
            end
            default: state_d = ST_ABSENT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ABSENT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_ins <= 1'b0;
            ev_rem <= 1'b0;
        end else begin
            ev_ins <= go_ins;
            ev_rem <= go_rem;
        end
    end

    assign status = (state_q == ST_PRESENT) || (state_q == ST_DISARMING);
endmodule

// File: rtl/pwrdet_flags.sv
module pwrdet_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_in,
    input  logic [N-1:0] clr_in,
    output logic [N-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_in) | set_in;
    end
endmodule

// File: rtl/pwr_src_detect.sv
module pwr_src_detect
    import pwrdet_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int DBNC_MS = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic [2:0]       raw_in,
    input  logic [2:0]       dbnc_en,
    input  logic [CNT_W-1:0] bat_ins_ms,
    input  logic [CNT_W-1:0] bat_rem_ms,
    input  logic [2:0]       flag_clr,
    output logic [2:0]       status,
    output logic [2:0]       flags,
    output logic [2:0]       ins_evt,
    output logic [2:0]       rem_evt
);
    localparam logic [CNT_W-1:0] FIXED_LIM = CNT_W'(DBNC_MS);

    logic [CNT_W-1:0] rise_lim [NSRC];
    logic [CNT_W-1:0] fall_lim [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        if (g == BAT_IDX) begin : g_bat
            assign rise_lim[g] = bat_ins_ms;
            assign fall_lim[g] = bat_rem_ms;
        end else begin : g_fix
            assign rise_lim[g] = FIXED_LIM;
            assign fall_lim[g] = FIXED_LIM;
        end

        pwrdet_filter #(.CNT_W(CNT_W)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick_ms),
            .raw      (raw_in[g]),
            .dbnc_en  (dbnc_en[g]),
            .rise_lim (rise_lim[g]),
            .fall_lim (fall_lim[g]),
            .status   (status[g]),
            .ev_ins   (ins_evt[g]),
            .ev_rem   (rem_evt[g])
        );
    end

    pwrdet_flags #(.N(NSRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_in (ins_evt | rem_evt),
        .clr_in (flag_clr),
        .flags  (flags)
    );
endmodule

// File: rtl/pwr_src_detect_chk.sv
module pwr_src_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] raw_in,
    input logic [2:0] dbnc_en,
    input logic [2:0] flag_clr,
    input logic [2:0] status,
    input logic [2:0] flags,
    input logic [2:0] ins_evt,
    input logic [2:0] rem_evt
);
    for (genvar i = 0; i < 3; i++) begin : g_chk
        assert_rise_has_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[i]) |-> ins_evt[i]);
        assert_fall_has_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status[i]) |-> rem_evt[i]);
        assert_evt_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(ins_evt[i] && rem_evt[i]));
        assert_evt_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ins_evt[i] || rem_evt[i]) |=> flags[i]);
        assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_clr[i] && !ins_evt[i] && !rem_evt[i]) |=> !flags[i]);
        assert_bypass_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!dbnc_en[i] && raw_in[i] != status[i]) |=> (status[i] == $past(raw_in[i])));
        assert_match_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_in[i] == status[i]) |=> $stable(status[i]));
    end
endmodule

bind pwr_src_detect pwr_src_detect_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (raw_in),
    .dbnc_en  (dbnc_en),
    .flag_clr (flag_clr),
    .status   (status),
    .flags    (flags),
    .ins_evt  (ins_evt),
    .rem_evt  (rem_evt)
);

// File: tb/pwr_src_detect_tb.sv
module pwr_src_detect_tb_top;
    localparam int CNT_W   = 8;
    localparam int DBNC_MS = 100;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_ms = 1'b0;
    logic [2:0]       raw_in = '0;
    logic [2:0]       dbnc_en = 3'b111;
    logic [CNT_W-1:0] bat_ins_ms = 8'd20;
    logic [CNT_W-1:0] bat_rem_ms = 8'd3;
    logic [2:0]       flag_clr = '0;
    logic [2:0]       status, flags, ins_evt, rem_evt;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    pwr_src_detect #(.CNT_W(CNT_W), .DBNC_MS(DBNC_MS)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .raw_in(raw_in),
        .dbnc_en(dbnc_en), .bat_ins_ms(bat_ins_ms), .bat_rem_ms(bat_rem_ms),
        .flag_clr(flag_clr), .status(status), .flags(flags),
        .ins_evt(ins_evt), .rem_evt(rem_evt)
    );

    // reference model built from the requirements
    bit m_st[3], m_pend[3], m_ins[3], m_rem[3], m_flag[3];
    int m_cnt[3];

    function automatic int lim_of(int s, bit rising);
        int v;
        if (s == 0) v = rising ? int'(bat_ins_ms) : int'(bat_rem_ms);
        else        v = DBNC_MS;
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < 3; s++) begin
                m_st[s] = 0; m_pend[s] = 0; m_ins[s] = 0; m_rem[s] = 0;
                m_flag[s] = 0; m_cnt[s] = 0;
            end
        end else begin
            for (int s = 0; s < 3; s++) begin
                bit ev_i, ev_r;
                m_flag[s] = (m_flag[s] & !flag_clr[s]) | m_ins[s] | m_rem[s];
                ev_i = 0; ev_r = 0;
                if (raw_in[s] == m_st[s]) begin
                    m_pend[s] = 0;
                end else if (!dbnc_en[s]) begin
                    m_st[s] = raw_in[s]; m_pend[s] = 0;
                    ev_i = raw_in[s]; ev_r = !raw_in[s];
                end else if (!m_pend[s]) begin
                    m_pend[s] = 1; m_cnt[s] = 0;
                end else if (tick_ms) begin
                    if (m_cnt[s] + 1 >= lim_of(s, raw_in[s])) begin
                        m_st[s] = raw_in[s]; m_pend[s] = 0;
                        ev_i = raw_in[s]; ev_r = !raw_in[s];
                    end else m_cnt[s]++;
                end
                m_ins[s] = ev_i; m_rem[s] = ev_r;
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n && !done) begin
            for (int s = 0; s < 3; s++) begin
                chk(status[s] == m_st[s], "R2/R3/R6 status", status[s], m_st[s]);
                chk(ins_evt[s] == m_ins[s], "R7 ins_evt", ins_evt[s], m_ins[s]);
                chk(rem_evt[s] == m_rem[s], "R7 rem_evt", rem_evt[s], m_rem[s]);
                chk(flags[s] == m_flag[s], "R8/R9 flags", flags[s], m_flag[s]);
            end
        end
    end

    // one tick every other cycle
    always @(negedge clk) tick_ms <= ~tick_ms;

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1_900_000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        int first_hi;
        cyc(3);
        // R1: reset state
        chk(status == 3'b000, "R1 status", status, 0);
        chk(flags == 3'b000, "R1 flags", flags, 0);
        chk((ins_evt | rem_evt) == 3'b000, "R1 events", ins_evt | rem_evt, 0);
        rst_n = 1'b1;
        cmp_on = 1;
        cyc(2);

        // R2/R10: DC (bit 1) held high needs ~DBNC_MS ticks
        raw_in[1] = 1'b1;
        cyc(150);
        chk(status[1] == 1'b0, "R2 early", status[1], 0);
        first_hi = 0;
        for (int k = 0; k < 120; k++) begin
            cyc(1);
            if (status[1] && first_hi == 0) first_hi = 150 + k + 1;
        end
        chk(first_hi >= 199 && first_hi <= 203, "R2 settle cycle", first_hi, 201);
        chk(status == 3'b010, "R10 bit map", status, 3'b010);
        chk(flags[1] == 1'b1, "R8 sticky", flags[1], 1);

        // R9: clear, and clear colliding with event
        flag_clr = 3'b010; cyc(1); flag_clr = '0; cyc(1);
        chk(flags[1] == 1'b0, "R9 clear", flags[1], 0);

        // R4: glitches on DC low shorter than period
        for (int g = 0; g < 5; g++) begin
            raw_in[1] = 1'b0; cyc(60);
            raw_in[1] = 1'b1; cyc(3);
        end
        chk(status[1] == 1'b1, "R4 glitch ignored", status[1], 1);
        chk(flags[1] == 1'b0, "R4 no flag", flags[1], 0);

        // R3: full removal
        raw_in[1] = 1'b0; cyc(230);
        chk(status[1] == 1'b0, "R3 removed", status[1], 0);

        // R6: battery asymmetric limits
        raw_in[0] = 1'b1; cyc(30);
        chk(status[0] == 1'b0, "R6 ins not yet", status[0], 0);
        cyc(20);
        chk(status[0] == 1'b1, "R6 ins done", status[0], 1);
        raw_in[0] = 1'b0; cyc(10);
        chk(status[0] == 1'b0, "R6 quick removal", status[0], 0);

        // R5: bypass on USB
        dbnc_en[2] = 1'b0;
        raw_in[2] = 1'b1; cyc(2);
        chk(status[2] == 1'b1, "R5 bypass set", status[2], 1);
        raw_in[2] = 1'b0; cyc(2);
        chk(status[2] == 1'b0, "R5 bypass clear", status[2], 0);

        // R9 collision: clear in same cycle as event keeps the flag
        flag_clr = 3'b100; cyc(1);
        raw_in[2] = 1'b1; cyc(1);           // status rises, ins_evt visible now
        chk(ins_evt[2] == 1'b1, "R7 pulse", ins_evt[2], 1);
        cyc(1);                              // flag_clr still 1 during event
        flag_clr = '0; cyc(1);
        chk(flags[2] == 1'b1, "R9 event wins", flags[2], 1);
        dbnc_en[2] = 1'b1;

        // R6: zero limit acts as one
        bat_ins_ms = 8'd0; bat_rem_ms = 8'd0;
        raw_in[0] = 1'b1; cyc(6);
        chk(status[0] == 1'b1, "R6 zero limit", status[0], 1);
        raw_in[0] = 1'b0; cyc(6);

        // constrained random phase
        void'($urandom(32'h5eed_1234));
        bat_ins_ms = 8'($urandom_range(1, 30));
        bat_rem_ms = 8'($urandom_range(1, 8));
        for (int n = 0; n < 12000; n++) begin
            for (int s = 0; s < 3; s++) begin
                if ($urandom_range(0, 199) == 0) raw_in[s] = ~raw_in[s];
                if ($urandom_range(0, 999) == 0) dbnc_en[s] = ~dbnc_en[s];
            end
            flag_clr = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(0, 7)) : 3'b000;
            cyc(1);
        end
        flag_clr = '0;
        cyc(4);
        done = 1;
        summary();
    end
endmodule